// File: doc/BRIEF.md
# Flow-Controlled Serial Byte Link

This block moves bytes over an asynchronous serial line in both directions. A bus-side write places a byte in a transmit queue. The transmitter takes bytes from that queue and sends each one as a ten-bit frame, pacing every bit from an external oversampling tick. The receiver recovers frames from the incoming line and stores their bytes in a receive queue. A read of the receive queue returns its oldest byte together with two constant fields that report both queue depths.

Optional low-active handshaking protects both directions. The peer's clear-to-send input holds back the start of each new frame. The request-to-send output tells the peer to stop once the receive queue reaches half of its capacity. An enable input gates the whole path. Dropping it empties both queues, stops any frame in flight and clears the sticky overrun flag. The tick generator and any interrupt logic sit outside this block.

Top module: `uart_fc_core`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. Each bit lasts 16 ticks of `baud_tick_i`. The line stays high whenever no frame is being sent.
- R2: The transmit and receive queues are first-in first-out, with depths set by `TX_DEPTH` and `RX_DEPTH` (each a power of two, at least 1). A write while the transmit queue is full is dropped.
- R3: Level flags: `rx_nempty_o` (level > 0), `rx_half_o` (2*level >= RX_DEPTH), `rx_full_o` (level == RX_DEPTH), `tx_empty_o` (level == 0), `tx_nhalf_o` (2*level < TX_DEPTH), `tx_full_o` (level == TX_DEPTH).
- R4: `tx_busy_o` is 1 while a frame is on the line or the transmit queue is not empty.
- R5: With `fc_en_i` high, no frame starts while `cts_ni` is high, and `tx_busy_o` stays 1 while a byte waits. With `fc_en_i` low, `cts_ni` is ignored.
- R6: `rts_no` is 0 whenever `fc_en_i` is 0. With `fc_en_i` at 1, `rts_no` is 1 when `en_i` is 0 or `rx_half_o` is 1, and 0 otherwise.
- R7: While `en_i` is 0, both queues are emptied, any frame stops with the line high, the overrun flag is cleared, and writes are ignored.
- R8: `rx_over_o` sets when a byte completes while the receive queue is full. That byte is dropped and the queued bytes are kept. The flag clears only through R7.
- R9: A start edge whose line is high again at mid-start-bit (8 ticks later) is rejected, and no byte is stored.
- R10: A frame whose stop bit is sampled low is discarded.
- R11: `rd_word_o[7:0]` is the oldest received byte. `rd_word_o[11:8]` is log2(RX_DEPTH) and `rd_word_o[15:12]` is log2(TX_DEPTH), which is 8'h32 at the default depths.
- R12: `rx_rd_i` removes the oldest received byte. A read while the queue is empty has no effect.
- R13: After reset the line is high, both queues are empty, busy and overrun are 0, and `rts_no` is 0 while flow control is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low flushes |
| fc_en_i | input | 1 | Handshake enable |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit |
| tx_wr_i | input | 1 | Push `tx_data_i` to transmit queue |
| tx_data_i | input | 8 | Byte to send |
| rx_rd_i | input | 1 | Pop oldest received byte |
| rd_word_o | output | 16 | Received byte and depth fields |
| txd_o | output | 1 | Serial output |
| rxd_i | input | 1 | Serial input |
| rts_no | output | 1 | Request to send, active low |
| cts_ni | input | 1 | Clear to send, active low |
| rx_nempty_o | output | 1 | Receive queue not empty |
| rx_half_o | output | 1 | Receive queue at least half full |
| rx_full_o | output | 1 | Receive queue full |
| rx_over_o | output | 1 | Sticky receive overrun |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_nhalf_o | output | 1 | Transmit queue below half |
| tx_full_o | output | 1 | Transmit queue full |
| tx_busy_o | output | 1 | Frame active or bytes queued |

## Verification
A bus write and a transmitter pop can land on the same clock edge. This happens whenever a byte is written while the transmitter takes the head of the queue to start a frame, with both changing the level at once. A back-to-back write burst provokes it: its second write coincides with the first frame start, and later writes fill the queue until further writes are dropped. The bench judges the result with a behavioural queue model that is checked against every level flag and the busy flag on every clock. It also decodes the serial line independently and compares each decoded byte with the byte the model popped.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int unsigned OSR        = 16;
  localparam int unsigned FRAME_BITS = 10;
  localparam int unsigned DATA_BITS  = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             half_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign half_o  = ((32'(count_q) * 2) >= DEPTH);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      if (do_push && !do_pop)      count_q <= count_q + CW'(1);
      else if (do_pop && !do_push) count_q <= count_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       fc_en_i,
  input  logic       cts_ni,
  input  logic       avail_i,
  input  logic [7:0] data_i,
  output logic       pop_o,
  output logic       txd_o,
  output logic       active_o
);
  logic       active_q, txd_q, start;
  logic [3:0] tcnt_q, bidx_q;
  logic [7:0] sh_q;

  assign start    = en_i && !active_q && avail_i && (!fc_en_i || !cts_ni);
  assign pop_o    = start;
  assign txd_o    = txd_q;
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      txd_q    <= 1'b1;
      tcnt_q   <= '0;
      bidx_q   <= '0;
      sh_q     <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      txd_q    <= 1'b1;
      tcnt_q   <= '0;
      bidx_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      txd_q    <= 1'b0;
      sh_q     <= data_i;
      tcnt_q   <= '0;
      bidx_q   <= '0;
    end else if (active_q && tick_i) begin
      if (tcnt_q == 4'(OSR - 1)) begin
        tcnt_q <= '0;
        if (bidx_q == 4'(FRAME_BITS - 1)) begin
          active_q <= 1'b0;
        end else begin
          bidx_q <= bidx_q + 4'd1;
          // bit after index k is data bit k, then stop
          txd_q  <= (bidx_q < 4'(DATA_BITS)) ? sh_q[bidx_q[2:0]] : 1'b1;
        end
      end else begin
        tcnt_q <= tcnt_q + 4'd1;
      end
    end
  end
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  rx_state_e  state_q;
  logic [1:0] sync_q;
  logic       rxs, valid_q;
  logic [3:0] cnt_q;
  logic [2:0] bidx_q;
  logic [7:0] sh_q;

  assign rxs     = sync_q[1];
  assign valid_o = valid_q;
  assign data_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rxs) state_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == 4'(OSR / 2 - 1)) begin
              cnt_q   <= '0;
              bidx_q  <= '0;
              state_q <= rxs ? RX_IDLE : RX_DATA;  // glitch rejection
            end else cnt_q <= cnt_q + 4'd1;
          end
          RX_DATA: begin
            if (cnt_q == 4'(OSR - 1)) begin
              cnt_q <= '0;
              sh_q  <= {rxs, sh_q[7:1]};
              if (bidx_q == 3'(DATA_BITS - 1)) state_q <= RX_STOP;
              else bidx_q <= bidx_q + 3'd1;
            end else cnt_q <= cnt_q + 4'd1;
          end
          RX_STOP: begin
            if (cnt_q == 4'(OSR - 1)) begin
              cnt_q   <= '0;
              state_q <= RX_IDLE;
              valid_q <= rxs;
            end else cnt_q <= cnt_q + 4'd1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_fc_core.sv
module uart_fc_core #(
  parameter int unsigned RX_DEPTH = 4,
  parameter int unsigned TX_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        fc_en_i,
  input  logic        baud_tick_i,
  input  logic        tx_wr_i,
  input  logic [7:0]  tx_data_i,
  input  logic        rx_rd_i,
  output logic [15:0] rd_word_o,
  output logic        txd_o,
  input  logic        rxd_i,
  output logic        rts_no,
  input  logic        cts_ni,
  output logic        rx_nempty_o,
  output logic        rx_half_o,
  output logic        rx_full_o,
  output logic        rx_over_o,
  output logic        tx_empty_o,
  output logic        tx_nhalf_o,
  output logic        tx_full_o,
  output logic        tx_busy_o
);
  localparam int unsigned RX_LOG = $clog2(RX_DEPTH);
  localparam int unsigned TX_LOG = $clog2(TX_DEPTH);

  logic       flush, tx_pop, tx_active, tx_half, rx_empty, rx_valid, over_q;
  logic [7:0] tx_head, rx_head, rx_byte;

  assign flush = !en_i;

  uart_fc_fifo #(.DEPTH(TX_DEPTH), .WIDTH(8)) tx_fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (tx_wr_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o),
    .half_o  (tx_half)
  );

  uart_fc_tx tx_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (baud_tick_i),
    .fc_en_i  (fc_en_i),
    .cts_ni   (cts_ni),
    .avail_i  (!tx_empty_o),
    .data_i   (tx_head),
    .pop_o    (tx_pop),
    .txd_o    (txd_o),
    .active_o (tx_active)
  );

  uart_fc_rx rx_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (baud_tick_i),
    .rxd_i   (rxd_i),
    .valid_o (rx_valid),
    .data_o  (rx_byte)
  );

  uart_fc_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) rx_fifo_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (rx_valid),
    .data_i  (rx_byte),
    .pop_i   (rx_rd_i),
    .data_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full_o),
    .half_o  (rx_half_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    over_q <= 1'b0;
    else if (flush)                 over_q <= 1'b0;
    else if (rx_valid && rx_full_o) over_q <= 1'b1;
  end

  assign rx_nempty_o = !rx_empty;
  assign rx_over_o   = over_q;
  assign tx_nhalf_o  = !tx_half;
  assign tx_busy_o   = tx_active || !tx_empty_o;
  assign rts_no      = fc_en_i && (!en_i || rx_half_o);
  assign rd_word_o   = {4'(TX_LOG), 4'(RX_LOG), rx_head};
endmodule

// File: rtl/uart_fc_sva.sv
module uart_fc_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic fc_en_i,
  input logic rts_no,
  input logic txd_o,
  input logic rx_nempty_o,
  input logic rx_half_o,
  input logic rx_full_o,
  input logic rx_over_o,
  input logic tx_empty_o,
  input logic tx_nhalf_o,
  input logic tx_full_o,
  input logic tx_busy_o
);
  assert_rx_levels_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> (rx_half_o && rx_nempty_o));
  assert_tx_levels_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> (!tx_nhalf_o && !tx_empty_o));
  assert_busy_queued_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_empty_o |-> tx_busy_o);
  assert_rts_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_en_i && rx_full_o) |-> rts_no);
  assert_flush_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tx_empty_o && !rx_nempty_o && !rx_over_o && txd_o));
  assert_over_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rx_over_o) |=> rx_over_o);
endmodule

bind uart_fc_core uart_fc_sva sva_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .fc_en_i     (fc_en_i),
  .rts_no      (rts_no),
  .txd_o       (txd_o),
  .rx_nempty_o (rx_nempty_o),
  .rx_half_o   (rx_half_o),
  .rx_full_o   (rx_full_o),
  .rx_over_o   (rx_over_o),
  .tx_empty_o  (tx_empty_o),
  .tx_nhalf_o  (tx_nhalf_o),
  .tx_full_o   (tx_full_o),
  .tx_busy_o   (tx_busy_o)
);

// File: tb/uart_fc_core_tb_top.sv
module uart_fc_core_tb_top;
  localparam int RXD = 4;
  localparam int TXD = 8;
  typedef logic [7:0] u8;

  logic clk = 0, rst_n = 0, en = 0, fc = 0, tick = 0;
  logic tx_wr = 0, rx_rd = 0, rxd_drv = 1, cts_n = 1, loop_en = 0;
  logic [7:0] tx_data = '0;
  logic [15:0] rd_word;
  logic txd, rxd, rts_n, rx_nempty, rx_half, rx_full, rx_over;
  logic tx_empty, tx_nhalf, tx_full, tx_busy;

  assign rxd = loop_en ? txd : rxd_drv;

  uart_fc_core #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fc_en_i(fc), .baud_tick_i(tick),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd), .rd_word_o(rd_word),
    .txd_o(txd), .rxd_i(rxd), .rts_no(rts_n), .cts_ni(cts_n),
    .rx_nempty_o(rx_nempty), .rx_half_o(rx_half), .rx_full_o(rx_full),
    .rx_over_o(rx_over), .tx_empty_o(tx_empty), .tx_nhalf_o(tx_nhalf),
    .tx_full_o(tx_full), .tx_busy_o(tx_busy)
  );

  always #5 clk = ~clk;
  initial forever begin @(negedge clk); tick = ~tick; end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  u8 tq[$], rq[$], tx_exp[$], tx_seen[$];
  bit m_act = 0, m_over = 0, rx_cmp = 1;
  int m_cnt = 0;

  always @(posedge clk) begin
    bit full_old, st;
    if (!rst_n) begin
      tq.delete(); rq.delete(); m_act = 0; m_over = 0; m_cnt = 0;
    end else if (!en) begin
      tq.delete(); rq.delete(); m_act = 0; m_over = 0;
    end else begin
      full_old = (tq.size() == TXD);
      st = !m_act && tq.size() > 0 && (!fc || !cts_n);
      if (st) begin tx_exp.push_back(tq.pop_front()); m_act = 1; m_cnt = 0; end
      else if (m_act && tick) begin m_cnt++; if (m_cnt == 160) m_act = 0; end
      if (tx_wr && !full_old) tq.push_back(tx_data);
      if (rx_rd && rq.size() > 0) void'(rq.pop_front());
    end
    #3;
    if (rst_n) begin
      chk("R3", "tx_empty", int'(tx_empty), int'(tq.size() == 0));
      chk("R3", "tx_full", int'(tx_full), int'(tq.size() == TXD));
      chk("R3", "tx_nhalf", int'(tx_nhalf), int'(2 * tq.size() < TXD));
      chk("R4", "tx_busy", int'(tx_busy), int'(m_act || tq.size() > 0));
      if (!m_act) chk("R1", "idle line", int'(txd), 1);
      if (rx_cmp) begin
        chk("R3", "rx_nempty", int'(rx_nempty), int'(rq.size() > 0));
        chk("R3", "rx_half", int'(rx_half), int'(2 * rq.size() >= RXD));
        chk("R3", "rx_full", int'(rx_full), int'(rq.size() == RXD));
        chk("R8", "rx_over", int'(rx_over), int'(m_over));
        chk("R6", "rts", int'(rts_n), int'(fc && (!en || 2 * rq.size() >= RXD)));
      end
    end
  end

  // independent line decoder
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge txd);
      repeat (16) @(negedge clk);
      chk("R1", "start bit", int'(txd), 0);
      for (int i = 0; i < 8; i++) begin repeat (32) @(negedge clk); b[i] = txd; end
      repeat (32) @(negedge clk);
      chk("R1", "stop bit", int'(txd), 1);
      tx_seen.push_back(b);
    end
  end

  task automatic wr_tx(input u8 b);
    tx_wr = 1; tx_data = b; @(negedge clk); tx_wr = 0;
  endtask

  task automatic wait_tx_idle();
    for (int i = 0; i < 4000; i++) begin @(negedge clk); if (!tx_busy) break; end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_stream(input string req);
    chk(req, "frame count", tx_seen.size(), tx_exp.size());
    for (int i = 0; i < tx_exp.size() && i < tx_seen.size(); i++)
      chk(req, "frame byte", int'(tx_seen[i]), int'(tx_exp[i]));
    tx_seen.delete(); tx_exp.delete();
  endtask

  task automatic send_rx(input u8 b, input bit good_stop);
    rx_cmp = 0;
    rxd_drv = 0; repeat (32) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd_drv = b[i]; repeat (32) @(negedge clk); end
    if (good_stop) begin
      rxd_drv = 1; repeat (32) @(negedge clk);
      if (en) begin if (rq.size() < RXD) rq.push_back(b); else m_over = 1; end
    end else begin
      rxd_drv = 0; repeat (24) @(negedge clk);
      rxd_drv = 1; repeat (40) @(negedge clk);
    end
    rx_cmp = 1;
  endtask

  task automatic rd_rx(input string req, input u8 exp);
    chk(req, "head byte", int'(rd_word[7:0]), int'(exp));
    rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int lows;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "txd", int'(txd), 1);
    chk("R13", "tx_empty", int'(tx_empty), 1);
    chk("R13", "rx_nempty", int'(rx_nempty), 0);
    chk("R13", "busy", int'(tx_busy), 0);
    chk("R13", "rts", int'(rts_n), 0);
    chk("R11", "depth fields", int'(rd_word[15:8]), 8'h32);

    en = 1; @(negedge clk);
    wr_tx(8'hA5); wr_tx(8'h3C);
    wait_tx_idle();
    check_stream("R1");

    // R2 burst: push coincides with pop, then queue fills
    for (int i = 0; i < 12; i++) wr_tx(u8'(8'h10 + i));
    chk("R2", "tx full after burst", int'(tx_full), 1);
    wait_tx_idle();
    chk("R2", "accepted bytes", tx_seen.size(), 9);
    check_stream("R2");

    // R12 read on empty, then R1/R11 receive
    rx_rd = 1; @(negedge clk); rx_rd = 0; @(negedge clk);
    chk("R12", "empty read", int'(rx_nempty), 0);
    send_rx(8'h5A, 1);
    chk("R12", "byte present", int'(rx_nempty), 1);
    rd_rx("R11", 8'h5A);
    @(negedge clk);
    chk("R12", "popped", int'(rx_nempty), 0);

    // R8 overrun
    for (int i = 0; i < 5; i++) send_rx(u8'(8'h11 * (i + 1)), 1);
    chk("R8", "over set", int'(rx_over), 1);
    chk("R3", "rx full", int'(rx_full), 1);
    rd_rx("R8", 8'h11); rd_rx("R8", 8'h22); rd_rx("R8", 8'h33); rd_rx("R8", 8'h44);
    chk("R8", "over sticky", int'(rx_over), 1);
    en = 0; repeat (2) @(negedge clk);
    chk("R7", "over cleared", int'(rx_over), 0);
    chk("R7", "rx flushed", int'(rx_nempty), 0);
    en = 1; @(negedge clk);

    // R9 glitch, R10 bad stop
    rx_cmp = 0; rxd_drv = 0; repeat (6) @(negedge clk); rxd_drv = 1; rx_cmp = 1;
    repeat (64) @(negedge clk);
    chk("R9", "glitch stored nothing", int'(rx_nempty), 0);
    send_rx(8'hF0, 0);
    chk("R10", "bad stop discarded", int'(rx_nempty), 0);
    send_rx(8'h96, 1);
    rd_rx("R10", 8'h96);

    // R6 request-to-send
    fc = 1; @(negedge clk);
    chk("R6", "rts empty", int'(rts_n), 0);
    send_rx(8'h01, 1);
    chk("R6", "rts one byte", int'(rts_n), 0);
    send_rx(8'h02, 1);
    chk("R6", "rts half", int'(rts_n), 1);
    en = 0; @(negedge clk);
    chk("R6", "rts disabled", int'(rts_n), 1);
    fc = 0; @(negedge clk);
    chk("R6", "rts no flow control", int'(rts_n), 0);
    en = 1; @(negedge clk);

    // R5 clear-to-send gating, R7 flush of waiting bytes
    fc = 1; cts_n = 1; @(negedge clk);
    wr_tx(8'h81); wr_tx(8'h7E);
    lows = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (!txd) lows++; end
    chk("R5", "line held", lows, 0);
    chk("R5", "busy while waiting", int'(tx_busy), 1);
    en = 0; @(negedge clk);
    chk("R7", "tx flushed", int'(tx_empty), 1);
    chk("R7", "busy cleared", int'(tx_busy), 0);
    en = 1; cts_n = 0; repeat (400) @(negedge clk);
    chk("R7", "flushed bytes not sent", tx_seen.size(), 0);
    wr_tx(8'h81);
    wait_tx_idle();
    check_stream("R5");
    fc = 0; cts_n = 1; @(negedge clk);
    wr_tx(8'h42);
    wait_tx_idle();
    chk("R5", "cts ignored without fc", tx_seen.size(), 1);
    check_stream("R5");

    // loopback
    loop_en = 1; rx_cmp = 0;
    wr_tx(8'hC3); wr_tx(8'h18);
    wait_tx_idle();
    repeat (40) @(negedge clk);
    rq.push_back(8'hC3); rq.push_back(8'h18);
    rx_cmp = 1; loop_en = 0;
    @(negedge clk);
    rd_rx("R1", 8'hC3); rd_rx("R1", 8'h18);
    check_stream("R1");
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule